// File: doc/BRIEF.md
# Ring Indicator Status and Interrupt Unit

This unit handles the ring-indicator line of a serial port's modem status word. The external ring line is brought into the clock domain through a configurable flop chain. Its settled level is shown as one status bit. A sticky change bit records each low-to-high transition of the settled line, and a modem-status interrupt request is raised when such a transition happens while the interrupt is enabled.

Software reads the status word through `rd_data`, which always shows the current state of the unit. Asserting `rd_strobe` for one clock marks that cycle as the status read. The read clears the change bit and the interrupt request on the next edge, unless a new rising transition is detected in that same cycle. For a few cycles after reset the edge detector only records the line level. A line that is already high when reset is released is therefore not taken as a ring event.

Top module: `ring_status_unit`

## Requirements
- R1: `rd_data[6]` shows the synchronised ring level. A change on `ring_in` that is set up before clock edge k shows on `rd_data[6]` after edge k+1.
- R2: A low-to-high change on `ring_in` set up before edge k sets `rd_data[2]` after edge k+2, once the unit has settled after reset.
- R3: A high-to-low change on `ring_in` never sets `rd_data[2]`.
- R4: Once set, `rd_data[2]` stays set until a cycle with `rd_strobe` high. It reads zero after the edge that ends that cycle.
- R5: When a rising transition is detected in the same cycle as a read, `rd_data[2]` and `irq_req` stay set after that edge.
- R6: A detected rising transition with `irq_enable` high sets `irq_req` on the same edge that sets `rd_data[2]`.
- R7: A detected rising transition with `irq_enable` low sets `rd_data[2]` but leaves `irq_req` low.
- R8: `irq_req` stays high until a read cycle and is low after the edge that ends it, unless R5 applies.
- R9: Bits 7, 5, 4, 3, 1 and 0 of `rd_data` always read zero.
- R10: While `rst_n` is low, `rd_data` and `irq_req` are zero. If `ring_in` is held high through reset and afterwards, neither `rd_data[2]` nor `irq_req` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_in | input | 1 | External ring-indicator line, asynchronous |
| rd_strobe | input | 1 | High for one cycle marks a read of the status word |
| irq_enable | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status word: bit 6 is the ring level, bit 2 is the rising-change flag |
| irq_req | output | 1 | Modem-status interrupt request |

## Verification
A wrong edge-history value would either set `rd_data[2]` on a falling or steady line, or fail to set it on a rise. Either fault is visible one edge after the settled level moves on `rd_data[6]`. A change flag or interrupt latch that loses its state, or ignores the read, differs from the expected value in the cycle right after the read or the event. A warm-up window that is too short sets the change bit a few cycles after reset when the line was held high through reset.

// File: rtl/ring_stat_pkg.sv
package ring_stat_pkg;
  localparam int STAT_W     = 8;
  localparam int LEVEL_POS  = 6;
  localparam int CHANGE_POS = 2;

  typedef logic [STAT_W-1:0] stat_word_t;

  localparam stat_word_t USED_MASK = stat_word_t'((1 << LEVEL_POS) | (1 << CHANGE_POS));
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ring_edge_detect.sv
module ring_edge_detect #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic armed,
  output logic rise
);
  localparam int CW = $clog2(SETTLE + 2);
  localparam logic [CW-1:0] ARM_AT = CW'(SETTLE + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hist_q, hist_d;
  logic          cnt_en;

  always_comb begin
    armed  = (cnt_q == ARM_AT);
    cnt_en = !armed;
    cnt_d  = cnt_q + 1'b1;
    hist_d = level;
    rise   = armed && level && !hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/ring_event_latch.sv
module ring_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic rd_strobe,
  input  logic irq_enable,
  output logic change_flag,
  output logic irq_pend
);
  logic change_q, change_d;
  logic irq_q, irq_d;
  logic upd_en;

  always_comb begin
    upd_en   = rise || rd_strobe;
    change_d = rise || (change_q && !rd_strobe);
    irq_d    = (rise && irq_enable) || (irq_q && !rd_strobe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      change_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (upd_en) begin
      change_q <= change_d;
      irq_q    <= irq_d;
    end
  end

  assign change_flag = change_q;
  assign irq_pend    = irq_q;
endmodule

// File: rtl/ring_status_unit.sv
module ring_status_unit
  import ring_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_in,
  input  logic              rd_strobe,
  input  logic              irq_enable,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_req
);
  logic rst_n_int;
  logic ring_lvl;
  logic edge_armed;
  logic ring_rise;
  logic change_flag;
  logic irq_pend;

  ring_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ring_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (ring_in),
    .q_sync  (ring_lvl)
  );

  ring_edge_detect #(.SETTLE(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n_int),
    .level (ring_lvl),
    .armed (edge_armed),
    .rise  (ring_rise)
  );

  ring_event_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .rise        (ring_rise),
    .rd_strobe   (rd_strobe),
    .irq_enable  (irq_enable),
    .change_flag (change_flag),
    .irq_pend    (irq_pend)
  );

  always_comb begin
    rd_data             = '0;
    rd_data[LEVEL_POS]  = ring_lvl;
    rd_data[CHANGE_POS] = change_flag;
  end

  assign irq_req = irq_pend;
endmodule

// File: rtl/ring_status_unit_chk.sv
module ring_status_unit_chk
  import ring_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic              irq_enable,
  input logic [STAT_W-1:0] rd_data,
  input logic              irq_req,
  input logic              edge_armed
);
  assert_spare_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED_MASK) == '0);

  assert_rise_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_armed && $rose(rd_data[LEVEL_POS]) |=> rd_data[CHANGE_POS]);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe && rd_data[CHANGE_POS] |=> rd_data[CHANGE_POS]);

  assert_read_clears_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !$rose(rd_data[LEVEL_POS]) |=> !rd_data[CHANGE_POS]);

  assert_irq_implies_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> rd_data[CHANGE_POS]);

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(irq_enable));

  assert_read_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !$rose(rd_data[LEVEL_POS]) |=> !irq_req);
endmodule

bind ring_status_unit ring_status_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe  (rd_strobe),
  .irq_enable (irq_enable),
  .rd_data    (rd_data),
  .irq_req    (irq_req),
  .edge_armed (edge_armed)
);

// File: tb/ring_status_unit_tb.sv
module ring_status_unit_tb;
  logic       clk;
  logic       rst_n;
  logic       ring_in;
  logic       rd_strobe;
  logic       irq_enable;
  logic [7:0] rd_data;
  logic       irq_req;

  int checks;
  int errors;
  bit done;

  ring_status_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_in    (ring_in),
    .rd_strobe  (rd_strobe),
    .irq_enable (irq_enable),
    .rd_data    (rd_data),
    .irq_req    (irq_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector fields: {ring, rd, en, exp_level(bit6), exp_change(bit2), exp_irq}.
  // Expected values are those seen one clock edge after the inputs are applied.
  localparam int NV = 24;
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b001_000, // 0  steady low
    6'b101_000, // 1  line goes high (R1 latency)
    6'b101_100, // 2  level visible
    6'b101_111, // 3  R2 flag and R6 irq set
    6'b101_111, // 4  R4 sticky
    6'b111_100, // 5  R4/R8 read clears
    6'b001_100, // 6  line falls
    6'b001_000, // 7
    6'b001_000, // 8  R3 fall does not set
    6'b100_000, // 9  rise with irq disabled
    6'b100_100, // 10
    6'b100_110, // 11 R7 flag without irq
    6'b011_100, // 12 read clears
    6'b001_000, // 13
    6'b101_000, // 14 rise
    6'b101_100, // 15
    6'b111_111, // 16 R5 read coincides with rise
    6'b111_100, // 17 second read clears
    6'b001_100, // 18
    6'b101_000, // 19 one-cycle pulse
    6'b001_100, // 20
    6'b001_011, // 21 pulse detected
    6'b010_000, // 22 R8 read clears irq
    6'b000_000  // 23
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_vec(input int idx);
    logic [5:0] v;
    v = VEC[idx];
    chk($sformatf("R1 level step %0d", idx), {7'd0, rd_data[6]}, {7'd0, v[2]});
    chk($sformatf("R2/R3/R4/R5 change step %0d", idx), {7'd0, rd_data[2]}, {7'd0, v[1]});
    chk($sformatf("R6/R7/R8 irq step %0d", idx), {7'd0, irq_req}, {7'd0, v[0]});
    chk($sformatf("R9 spare bits step %0d", idx), rd_data & 8'hBB, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; ring_in = 1'b0; rd_strobe = 1'b0; irq_enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset data", rd_data, 8'h00);
    chk("R10 reset irq", {7'd0, irq_req}, 8'h00);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) chk_vec(i - 1);
      ring_in    = VEC[i][5];
      rd_strobe  = VEC[i][4];
      irq_enable = VEC[i][3];
      @(negedge clk);
    end
    chk_vec(NV - 1);

    // R10: line held high through reset and afterwards
    rst_n = 1'b0; ring_in = 1'b1; irq_enable = 1'b1; rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset data with line high", rd_data, 8'h00);
    chk("R10 reset irq with line high", {7'd0, irq_req}, 8'h00);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 no event after reset", rd_data, 8'h40);
    chk("R10 no irq after reset", {7'd0, irq_req}, 8'h00);

    // R3: fall after that reset still sets nothing
    ring_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 fall leaves flag clear", rd_data, 8'h00);
    chk("R3 fall leaves irq clear", {7'd0, irq_req}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule